// File: doc/BRIEF.md
# Priority Cell Queue with Partial Precedence and Partial Push-out

This block is the cell buffer of one switch output port. Every cell carries a short tag and two independent class bits. One bit sets its urgency, meaning how early it should leave. The other sets its protection, meaning how strongly it should resist being discarded. The queue is kept in order from the head, and the head cell is offered on the dequeue side. A consumer takes the head by raising a dequeue request.

Two thresholds, both writable at any time, decide where an arrival goes and what happens when the buffer is full. The jump limit is the largest number of non-urgent cells that an urgent arrival may overtake. The guard depth marks the protected region at the head. When the buffer is full, a protected arrival may evict the non-protected cell nearest the tail, but only if that cell lies at or below the guard depth. With the right settings the block acts as a plain first-come first-served queue, a strict urgency-first queue, a push-out queue, or urgency-first with push-out.

Each arrival that is refused or that displaces another cell raises a one-cycle event. The event carries the two class bits of the cell that was lost.

Top module: `prio_cell_queue`

## Requirements
- R1: After reset the queue is empty: `count` is 0, `deq_valid` is 0, and `drop_pulse`, `pushout_pulse`, `evt_urgent` and `evt_protect` are all 0.
- R2: A non-urgent arrival (`enq_urgent`=0) that is admitted goes to the tail. Cells of the same urgency leave in the order they arrived.
- R3: An admitted urgent arrival moves ahead of the run of non-urgent cells at the tail. It moves past at most `cfg_jump` of them and never past an urgent cell.
- R4: With `cfg_jump`=0 the departure order equals the arrival order. With `cfg_jump` at or above DEPTH, every urgent cell leaves before every non-urgent cell that was queued with it.
- R5: `deq_valid`, `deq_tag`, `deq_urgent` and `deq_protect` show slot 0, the head. A clock edge with `deq_req`=1 and a non-empty queue removes the head. `count` always equals the number of queued cells.
- R6: When a departure and an arrival occur at the same edge, the departure is applied first. Fullness is then judged on the queue left after that departure, so a full queue that is being read admits the arrival without loss.
- R7: If the queue is full after the departure step, an arriving cell with `enq_protect`=0 is discarded. The queue is left unchanged and `drop_pulse` is raised with the arrival's class bits.
- R8: If the queue is full and the arrival has `enq_protect`=1, the non-protected cell with the largest position index p ≥ `cfg_guard` (index 0 is the head) is removed. The arrival is then placed by the rules of R2 and R3, and `pushout_pulse` is raised with the removed cell's class bits.
- R9: If R8 finds no such cell, the protected arrival is discarded with `drop_pulse`. With `cfg_guard` at or above DEPTH, push-out never takes place.
- R10: Events are registered. They are high only for the single cycle that follows the edge that processed the arrival, and at most one of `drop_pulse` and `pushout_pulse` is high at a time. With no event, `evt_urgent` and `evt_protect` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | An arriving cell is presented |
| enq_tag | input | TAG_W | Tag of the arriving cell |
| enq_urgent | input | 1 | Arriving cell is in the urgent (high delay priority) class |
| enq_protect | input | 1 | Arriving cell is in the protected (high loss priority) class |
| deq_req | input | 1 | Remove the head cell at this edge |
| deq_valid | output | 1 | The head slot holds a cell |
| deq_tag | output | TAG_W | Tag of the head cell |
| deq_urgent | output | 1 | Urgency bit of the head cell |
| deq_protect | output | 1 | Protection bit of the head cell |
| cfg_jump | input | CNT_W | Jump limit: most non-urgent cells an urgent arrival may pass |
| cfg_guard | input | CNT_W | Guard depth: lowest slot index that may be pushed out |
| count | output | CNT_W | Number of queued cells |
| drop_pulse | output | 1 | The previous edge discarded the arrival |
| pushout_pulse | output | 1 | The previous edge evicted a queued cell |
| evt_urgent | output | 1 | Urgency bit of the lost cell |
| evt_protect | output | 1 | Protection bit of the lost cell |

## Verification
Every decision is taken at the edge that samples the inputs. The queue contents, `count` and the head outputs all change at that edge. The events belong to the same edge and stay high only for the cycle that follows it. The bench therefore drives each cycle's inputs on the falling edge and advances its behavioural model over that cycle's arrival, departure and thresholds. It compares every output on the next falling edge, exactly one rising edge later. The directed cases fix the event bits and the departure order for each threshold corner. A long random phase with shifting thresholds compares the head and the events on every cycle.

// File: rtl/pcq_pkg.sv
package pcq_pkg;
  parameter int TAG_W = 8;

  typedef struct packed {
    logic             urgent;
    logic             protect;
    logic [TAG_W-1:0] tag;
  } cell_t;
endpackage

// File: rtl/pcq_victim_sel.sv
module pcq_victim_sel #(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0] valid,
  input  logic [DEPTH-1:0] exposed,
  input  logic [CNT_W-1:0] guard,
  output logic             found,
  output logic [CNT_W-1:0] idx
);
  // The highest-index slot that is occupied, non-protected and not inside the guard region.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (valid[i] && exposed[i] && (CNT_W'(i) >= guard)) begin
        found = 1'b1;
        idx   = CNT_W'(i);
      end
    end
  end
endmodule

// File: rtl/pcq_place_sel.sv
module pcq_place_sel #(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0] valid,
  input  logic [DEPTH-1:0] relaxed,
  input  logic [CNT_W-1:0] fill,
  input  logic [CNT_W-1:0] jump,
  input  logic             arr_urgent,
  output logic [CNT_W-1:0] pos
);
  logic [CNT_W-1:0] tail_run;
  logic             blocked;

  function automatic logic [CNT_W-1:0] cap(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  // Length of the run of non-urgent cells at the tail.
  always_comb begin
    tail_run = '0;
    blocked  = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (valid[i] && !blocked) begin
        if (relaxed[i]) tail_run = tail_run + 1'b1;
        else            blocked  = 1'b1;
      end
    end
    pos = arr_urgent ? fill - cap(tail_run, jump) : fill;
  end
endmodule

// File: rtl/prio_cell_queue.sv
module prio_cell_queue #(
  parameter int DEPTH = 8,
  parameter int TAG_W = pcq_pkg::TAG_W,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_valid,
  input  logic [TAG_W-1:0] enq_tag,
  input  logic             enq_urgent,
  input  logic             enq_protect,
  input  logic             deq_req,
  output logic             deq_valid,
  output logic [TAG_W-1:0] deq_tag,
  output logic             deq_urgent,
  output logic             deq_protect,
  input  logic [CNT_W-1:0] cfg_jump,
  input  logic [CNT_W-1:0] cfg_guard,
  output logic [CNT_W-1:0] count,
  output logic             drop_pulse,
  output logic             pushout_pulse,
  output logic             evt_urgent,
  output logic             evt_protect
);
  import pcq_pkg::*;

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  cell_t            slot_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [CNT_W-1:0] cnt_q;

  // Pipeline of combinational views: after pop (s1), after eviction (s2), after insert (s3).
  cell_t            s0x [DEPTH+1];
  cell_t            s1x [DEPTH+1];
  cell_t            s2  [DEPTH];
  cell_t            s2u [DEPTH];
  cell_t            s3  [DEPTH];
  logic [DEPTH:0]   v0x, v1x;
  logic [DEPTH-1:0] v2, v2u, v3;
  logic [DEPTH-1:0] s1_exposed, s2_relaxed;
  cell_t            arrival;

  logic             pop_ev, full_ev, victim_ok, evict_ev, drop_ev, admit_ev;
  logic [CNT_W-1:0] n1, n2, victim_idx, ins_pos;

  logic drop_q, push_q, evt_u_q, evt_p_q;

  assign arrival = '{urgent: enq_urgent, protect: enq_protect, tag: enq_tag};

  // Departure first.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      s0x[i] = slot_q[i];
      v0x[i] = vld_q[i];
    end
    s0x[DEPTH] = '0;
    v0x[DEPTH] = 1'b0;
    pop_ev = deq_req && vld_q[0];
    for (int i = 0; i < DEPTH; i++) begin
      s1x[i] = pop_ev ? s0x[i+1] : s0x[i];
      v1x[i] = pop_ev ? v0x[i+1] : v0x[i];
    end
    s1x[DEPTH] = '0;
    v1x[DEPTH] = 1'b0;
    for (int i = 0; i < DEPTH; i++) s1_exposed[i] = !s1x[i].protect;
  end

  assign n1      = cnt_q - CNT_W'(pop_ev);
  assign full_ev = (n1 == FULL_CNT);

  pcq_victim_sel #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_victim (
    .valid   (v1x[DEPTH-1:0]),
    .exposed (s1_exposed),
    .guard   (cfg_guard),
    .found   (victim_ok),
    .idx     (victim_idx)
  );

  assign evict_ev = enq_valid && full_ev && enq_protect && victim_ok;
  assign drop_ev  = enq_valid && full_ev && !evict_ev;
  assign admit_ev = enq_valid && !drop_ev;
  assign n2       = n1 - CNT_W'(evict_ev);

  // Remove the victim and close the gap.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (evict_ev && (CNT_W'(i) >= victim_idx)) begin
        s2[i] = s1x[i+1];
        v2[i] = v1x[i+1];
      end else begin
        s2[i] = s1x[i];
        v2[i] = v1x[i];
      end
      s2_relaxed[i] = !s2[i].urgent;
    end
  end

  pcq_place_sel #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_place (
    .valid      (v2),
    .relaxed    (s2_relaxed),
    .fill       (n2),
    .jump       (cfg_jump),
    .arr_urgent (enq_urgent),
    .pos        (ins_pos)
  );

  // Open a hole at the insert position.
  always_comb begin
    s2u[0] = '0;
    v2u[0] = 1'b0;
    for (int i = 1; i < DEPTH; i++) begin
      s2u[i] = s2[i-1];
      v2u[i] = v2[i-1];
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (!admit_ev || (CNT_W'(i) < ins_pos)) begin
        s3[i] = s2[i];
        v3[i] = v2[i];
      end else if (CNT_W'(i) == ins_pos) begin
        s3[i] = arrival;
        v3[i] = 1'b1;
      end else begin
        s3[i] = s2u[i];
        v3[i] = v2u[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
      vld_q   <= '0;
      cnt_q   <= '0;
      drop_q  <= 1'b0;
      push_q  <= 1'b0;
      evt_u_q <= 1'b0;
      evt_p_q <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= s3[i];
      vld_q  <= v3;
      cnt_q  <= n2 + CNT_W'(admit_ev);
      drop_q <= drop_ev;
      push_q <= evict_ev;
      if (drop_ev) begin
        evt_u_q <= enq_urgent;
        evt_p_q <= enq_protect;
      end else if (evict_ev) begin
        evt_u_q <= s1x[victim_idx].urgent;
        evt_p_q <= s1x[victim_idx].protect;
      end else begin
        evt_u_q <= 1'b0;
        evt_p_q <= 1'b0;
      end
    end
  end

  assign deq_valid     = vld_q[0];
  assign deq_tag       = slot_q[0].tag;
  assign deq_urgent    = slot_q[0].urgent;
  assign deq_protect   = slot_q[0].protect;
  assign count         = cnt_q;
  assign drop_pulse    = drop_q;
  assign pushout_pulse = push_q;
  assign evt_urgent    = evt_u_q;
  assign evt_protect   = evt_p_q;

  // Checks next to the logic they guard.
  assert_one_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drop_pulse, pushout_pulse}));

  assert_count_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == CNT_W'($countones(vld_q)));

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  assert_victim_unprotected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pushout_pulse |-> !evt_protect);

  assert_drop_needs_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pulse |-> $past(full_ev && enq_valid));

  assert_full_stays_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && full_ev) |=> (cnt_q == FULL_CNT));

  generate
    for (genvar g = 1; g < DEPTH; g++) begin : g_contig
      assert_contiguous_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q[g] |-> vld_q[g-1]);
    end
  endgenerate
endmodule

// File: tb/prio_cell_queue_bench.sv
module prio_cell_queue_bench;
  localparam int D  = 8;
  localparam int TW = 8;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enq_valid = 1'b0, enq_urgent = 1'b0, enq_protect = 1'b0, deq_req = 1'b0;
  logic [TW-1:0] enq_tag = '0;
  logic [CW-1:0] cfg_jump = '0, cfg_guard = '0;
  logic          deq_valid, deq_urgent, deq_protect;
  logic [TW-1:0] deq_tag;
  logic [CW-1:0] count;
  logic          drop_pulse, pushout_pulse, evt_urgent, evt_protect;

  always #5 clk = ~clk;

  prio_cell_queue u_prio_cell_queue (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_tag(enq_tag),
    .enq_urgent(enq_urgent), .enq_protect(enq_protect), .deq_req(deq_req),
    .deq_valid(deq_valid), .deq_tag(deq_tag), .deq_urgent(deq_urgent),
    .deq_protect(deq_protect), .cfg_jump(cfg_jump), .cfg_guard(cfg_guard),
    .count(count), .drop_pulse(drop_pulse), .pushout_pulse(pushout_pulse),
    .evt_urgent(evt_urgent), .evt_protect(evt_protect)
  );

  // Model cell: {urgent, protect, tag}
  logic [TW+1:0] mq[$];
  int    checks = 0, errors = 0;
  bit    done = 0;
  string cur_req = "R1";
  bit    m_drop, m_push, m_eu, m_ep;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  function automatic void model_step(input bit ev, input logic [TW-1:0] tg, input bit u, input bit p,
                                     input bit dq, input int jl, input int gd);
    bit drop = 0;
    int pos, passed;
    m_drop = 0; m_push = 0; m_eu = 0; m_ep = 0;
    if (dq && mq.size() > 0) void'(mq.pop_front());
    if (ev) begin
      if (mq.size() == D) begin
        int vi = -1;
        if (p) for (int i = D - 1; i >= gd; i--) if (!mq[i][TW]) begin vi = i; break; end
        if (vi >= 0) begin
          m_push = 1; m_eu = mq[vi][TW+1]; m_ep = mq[vi][TW];
          mq.delete(vi);
        end else begin
          drop = 1; m_drop = 1; m_eu = u; m_ep = p;
        end
      end
      if (!drop) begin
        pos = mq.size(); passed = 0;
        if (u) while (pos > 0 && passed < jl && !mq[pos-1][TW+1]) begin pos--; passed++; end
        mq.insert(pos, {u, p, tg});
      end
    end
  endfunction

  task automatic step(input bit ev, input logic [TW-1:0] tg, input bit u, input bit p, input bit dq);
    enq_valid = ev; enq_tag = tg; enq_urgent = u; enq_protect = p; deq_req = dq;
    model_step(ev, tg, u, p, dq, int'(cfg_jump), int'(cfg_guard));
    @(posedge clk);
    @(negedge clk);
    chk(count == CW'(mq.size()), "count", count, mq.size());
    chk(deq_valid == (mq.size() > 0), "deq_valid", deq_valid, mq.size() > 0);
    if (mq.size() > 0)
      chk({deq_urgent, deq_protect, deq_tag} == mq[0], "head", {deq_urgent, deq_protect, deq_tag}, mq[0]);
    chk(drop_pulse == m_drop, "R10 drop_pulse", drop_pulse, m_drop);
    chk(pushout_pulse == m_push, "R10 pushout_pulse", pushout_pulse, m_push);
    chk({evt_urgent, evt_protect} == {m_eu, m_ep}, "R10 event bits", {evt_urgent, evt_protect}, {m_eu, m_ep});
  endtask

  task automatic idle(); step(0, '0, 0, 0, 0); endtask
  task automatic drain(); while (mq.size() > 0) step(0, '0, 0, 0, 1); endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cur_req = "R1";
    chk(count == 0 && !deq_valid, "empty after reset", count, 0);
    chk(!drop_pulse && !pushout_pulse && !evt_urgent && !evt_protect, "events after reset",
        {drop_pulse, pushout_pulse, evt_urgent, evt_protect}, 0);

    // R4 / R2: jump limit 0 gives arrival order
    cur_req = "R4"; cfg_jump = 0; cfg_guard = 8;
    step(1, 8'h10, 0, 0, 0); step(1, 8'h11, 1, 0, 0);
    step(1, 8'h12, 0, 1, 0); step(1, 8'h13, 1, 1, 0);
    drain();

    // R4: jump limit >= depth, urgent first
    cfg_jump = 9;
    step(1, 8'h20, 0, 0, 0); step(1, 8'h21, 0, 0, 0);
    step(1, 8'h22, 1, 0, 0); step(1, 8'h23, 1, 0, 0);
    drain();

    // R3: partial jump of two, never past an urgent cell
    cur_req = "R3"; cfg_jump = 2;
    for (int i = 0; i < 4; i++) step(1, 8'h30 + 8'(i), 0, 0, 0);
    step(1, 8'h3A, 1, 0, 0); step(1, 8'h3B, 1, 0, 0);
    cur_req = "R2";
    step(1, 8'h3C, 0, 0, 0);
    drain();

    // R7: full, non-protected arrival dropped
    cur_req = "R7"; cfg_guard = 3; cfg_jump = 0;
    for (int i = 0; i < D; i++) step(1, 8'h40 + 8'(i), i[0], 0, 0);
    step(1, 8'h4F, 1, 0, 0);
    // R8: protected arrival evicts highest non-protected cell at index >= 3
    cur_req = "R8";
    step(1, 8'h50, 0, 1, 0);
    step(1, 8'h51, 1, 1, 0);
    drain();

    // R9: all protected beyond guard -> drop; guard >= depth -> no push-out
    cur_req = "R9"; cfg_guard = 6;
    for (int i = 0; i < D; i++) step(1, 8'h60 + 8'(i), 0, (i >= 6), 0);
    step(1, 8'h6F, 0, 1, 0);
    cfg_guard = 8;
    step(1, 8'h6E, 1, 1, 0);
    drain();

    // R6: full queue read and written at the same edge
    cur_req = "R6";
    for (int i = 0; i < D; i++) step(1, 8'h70 + 8'(i), 0, 0, 0);
    step(1, 8'h7F, 0, 0, 1);
    // R5: pure dequeue
    cur_req = "R5";
    step(0, '0, 0, 0, 1);
    drain();
    step(0, '0, 0, 0, 1);

    // Random mix with moving thresholds
    cur_req = "R10";
    for (int c = 0; c < 4000; c++) begin
      if (c % 97 == 0) begin
        cfg_jump = CW'($urandom_range(0, 9));
        cfg_guard = CW'($urandom_range(0, 9));
      end
      step($urandom_range(0, 3) != 0, 8'($urandom), 1'($urandom), 1'($urandom),
           $urandom_range(0, 2) == 0);
    end
    idle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule